// File: doc/BRIEF.md
# Bidirectional Timer Count Unit

This block holds the count register of a timer and moves it by one step on each qualified timer tick. A tick is taken either from a synchronous system-rate strobe or from a strobe that stands for a fast auxiliary clock. Both arrive as single-cycle enables in the block's one clock domain. A multi-bit clock-select field stops the timer while it is zero. On a tick, the count is cleared, incremented or decremented as the clear, enable and direction controls request. The count wraps modulo 2^W in both directions.

A processor port can load the count at any time, whether or not a tick is present, and the load wins over any clear or step in the same cycle. The count is always visible on the read port. Two combinational decodes flag the maximum and zero values.

A sticky overflow flag records a terminal event. In normal mode that event is an upward wrap from maximum to zero. In dual-slope mode it is a downward step that lands on zero. A write-one-to-clear strobe removes the flag. A surrounding PWM or interrupt unit consumes the decodes and the flag.

Top module: `bidir_tick_counter`

## Requirements
- R1: On a qualified tick with no processor write, `cnt_clr`=1 sets the count to 0. Otherwise `cnt_en`=1 adds one (`cnt_down`=0) or subtracts one (`cnt_down`=1), modulo 256. Otherwise the count holds. A step is visible on `cpu_rdata` one clock after the edge that samples the tick.
- R2: `fast_en`=1 makes `fast_tick` the tick source and `sys_tick` is then ignored. `fast_en`=0 makes `sys_tick` the source and `fast_tick` is then ignored.
- R3: While `clk_sel` equals 0, no tick is qualified. The count and the overflow flag keep their values whatever the tick, enable and clear inputs do.
- R4: `cpu_rdata` always shows the current count, and a processor write is visible there after one clock even while `clk_sel` is 0.
- R5: `cpu_wr`=1 loads `cpu_wdata` into the count and overrides any clear or step in that cycle. A write cycle never raises the overflow flag.
- R6: `at_top` is 1 exactly when the count is 8'hFF, and `at_bottom` is 1 exactly when the count is 8'h00.
- R7: With `dual_slope`=0, an upward step from 8'hFF to 8'h00 sets `ovf_flag` on the next clock.
- R8: With `dual_slope`=1, a downward step from 8'h01 to 8'h00 sets `ovf_flag`. A downward wrap from 8'h00 to 8'hFF does not set it, and neither does any upward step.
- R9: `ovf_flag` stays set until a cycle with `ovf_clr`=1. If a set event occurs in that same cycle, the flag stays set.
- R10: While `rst_n` is low, the count is 0 and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| sys_tick | input | 1 | Synchronous timer strobe |
| fast_tick | input | 1 | Fast-clock timer strobe (single-cycle enable) |
| clk_sel | input | 4 | Clock-select field; zero stops the timer |
| fast_en | input | 1 | Choose the fast strobe as tick source |
| cnt_en | input | 1 | Step enable on a tick |
| cnt_down | input | 1 | Direction: 1 = decrement |
| cnt_clr | input | 1 | Clear on a tick |
| dual_slope | input | 1 | Overflow rule: 0 = up wrap, 1 = reaching zero downward |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| cpu_rdata | output | 8 | Current count |
| at_top | output | 1 | Count equals maximum |
| at_bottom | output | 1 | Count equals zero |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong count shows on `cpu_rdata` and on the two decodes one clock after the edge that sampled the faulty step, clear or load. It keeps showing there until the next processor write hides it. A fault in the overflow logic can stay hidden for up to 256 ticks, because the flag only reacts at a wrap or a landing on zero. Those wrap and landing points are therefore driven deliberately, in both modes and with a clear strobe arriving in the same cycle. A wrong tick-source choice shows as a step that happens or is missing in the next cycle while the unselected strobe toggles.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_LOAD,
    ACT_CLEAR,
    ACT_INC,
    ACT_DEC
  } cnt_act_e;

  // Priority: processor load, then clear, then step, all but load need a tick.
  function automatic cnt_act_e pick_action(input logic wr, input logic tick,
                                           input logic clr, input logic en,
                                           input logic down);
    cnt_act_e a;
    if (wr)                a = ACT_LOAD;
    else if (!tick)        a = ACT_HOLD;
    else if (clr)          a = ACT_CLEAR;
    else if (en && down)   a = ACT_DEC;
    else if (en)           a = ACT_INC;
    else                   a = ACT_HOLD;
    return a;
  endfunction

endpackage

// File: rtl/bdc_tick_select.sv
module bdc_tick_select #(
  parameter int SEL_W    = 4,
  parameter bit HAS_FAST = 1'b1
) (
  input  logic             sys_tick,
  input  logic             fast_tick,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             fast_en,
  output logic             timer_tick
);
  logic src_tick;
  logic sel_on;

  assign sel_on = |clk_sel;

  generate
    if (HAS_FAST) begin : g_two_src
      assign src_tick = fast_en ? fast_tick : sys_tick;
    end else begin : g_sys_only
      logic unused_fast;
      assign unused_fast = fast_tick ^ fast_en;
      assign src_tick    = sys_tick;
    end
  endgenerate

  assign timer_tick = sel_on & src_tick;
endmodule

// File: rtl/bdc_count_reg.sv
module bdc_count_reg
  import bdc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_act_e     act,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         at_top,
  output logic         at_bottom,
  output logic         evt_up_wrap,
  output logic         evt_down_bottom
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_MIN = '0;
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] next_count(input cnt_act_e a,
                                               input logic [W-1:0] cur,
                                               input logic [W-1:0] ld);
    logic [W-1:0] n;
    case (a)
      ACT_LOAD:  n = ld;
      ACT_CLEAR: n = CNT_MIN;
      ACT_INC:   n = cur + CNT_ONE;
      ACT_DEC:   n = cur - CNT_ONE;
      default:   n = cur;
    endcase
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= CNT_MIN;
    else        count <= next_count(act, count, load_val);
  end

  assign at_top          = (count == CNT_MAX);
  assign at_bottom       = (count == CNT_MIN);
  assign evt_up_wrap     = (act == ACT_INC) && (count == CNT_MAX);
  assign evt_down_bottom = (act == ACT_DEC) && (count == CNT_ONE);
endmodule

// File: rtl/bdc_ovf_flag.sv
module bdc_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_slope,
  input  logic evt_up_wrap,
  input  logic evt_down_bottom,
  input  logic ovf_clr,
  output logic ovf_flag
);
  logic set_evt;

  assign set_evt = dual_slope ? evt_down_bottom : evt_up_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (set_evt) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/bidir_tick_counter.sv
module bidir_tick_counter
  import bdc_pkg::*;
#(
  parameter int W     = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_tick,
  input  logic             fast_tick,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             fast_en,
  input  logic             cnt_en,
  input  logic             cnt_down,
  input  logic             cnt_clr,
  input  logic             dual_slope,
  input  logic             cpu_wr,
  input  logic [W-1:0]     cpu_wdata,
  input  logic             ovf_clr,
  output logic [W-1:0]     cpu_rdata,
  output logic             at_top,
  output logic             at_bottom,
  output logic             ovf_flag
);
  logic         timer_tick;
  cnt_act_e     act;
  logic [W-1:0] count;
  logic         evt_up_wrap;
  logic         evt_down_bottom;

  bdc_tick_select #(.SEL_W(SEL_W), .HAS_FAST(1'b1)) u_tick (
    .sys_tick  (sys_tick),
    .fast_tick (fast_tick),
    .clk_sel   (clk_sel),
    .fast_en   (fast_en),
    .timer_tick(timer_tick)
  );

  assign act = pick_action(cpu_wr, timer_tick, cnt_clr, cnt_en, cnt_down);

  bdc_count_reg #(.W(W)) u_cnt (
    .clk            (clk),
    .rst_n          (rst_n),
    .act            (act),
    .load_val       (cpu_wdata),
    .count          (count),
    .at_top         (at_top),
    .at_bottom      (at_bottom),
    .evt_up_wrap    (evt_up_wrap),
    .evt_down_bottom(evt_down_bottom)
  );

  bdc_ovf_flag u_ovf (
    .clk            (clk),
    .rst_n          (rst_n),
    .dual_slope     (dual_slope),
    .evt_up_wrap    (evt_up_wrap),
    .evt_down_bottom(evt_down_bottom),
    .ovf_clr        (ovf_clr),
    .ovf_flag       (ovf_flag)
  );

  assign cpu_rdata = count;
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
  parameter int W     = 8,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] clk_sel,
  input logic             cnt_en,
  input logic             cnt_down,
  input logic             cnt_clr,
  input logic             dual_slope,
  input logic             cpu_wr,
  input logic [W-1:0]     cpu_wdata,
  input logic             ovf_clr,
  input logic [W-1:0]     cpu_rdata,
  input logic             at_top,
  input logic             at_bottom,
  input logic             ovf_flag,
  input logic             timer_tick,
  input logic             evt_up_wrap,
  input logic             evt_down_bottom
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && timer_tick && cnt_clr) |=> (cpu_rdata == '0)); // R1
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && timer_tick && !cnt_clr && cnt_en && !cnt_down)
      |=> (cpu_rdata == W'($past(cpu_rdata) + 1'b1))); // R1
  AST_NO_CLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && clk_sel == '0) |=> ($stable(cpu_rdata) && $stable(ovf_flag) || (ovf_flag == 1'b0))); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (cpu_rdata == $past(cpu_wdata))); // R5
  AST_TOP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_up_wrap |-> at_top); // R6
  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_up_wrap && !dual_slope) |=> (ovf_flag && at_bottom)); // R7
  AST_DUAL_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_down_bottom && dual_slope) |=> (ovf_flag && at_bottom)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(dual_slope ? evt_down_bottom : evt_up_wrap)) |=> !ovf_flag); // R9
endmodule

bind bidir_tick_counter bdc_checker #(.W(W), .SEL_W(SEL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clk_sel        (clk_sel),
  .cnt_en         (cnt_en),
  .cnt_down       (cnt_down),
  .cnt_clr        (cnt_clr),
  .dual_slope     (dual_slope),
  .cpu_wr         (cpu_wr),
  .cpu_wdata      (cpu_wdata),
  .ovf_clr        (ovf_clr),
  .cpu_rdata      (cpu_rdata),
  .at_top         (at_top),
  .at_bottom      (at_bottom),
  .ovf_flag       (ovf_flag),
  .timer_tick     (timer_tick),
  .evt_up_wrap    (evt_up_wrap),
  .evt_down_bottom(evt_down_bottom)
);

// File: tb/sim_bidir_tick_counter.sv
module sim_bidir_tick_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sys_tick, fast_tick, fast_en, cnt_en, cnt_down, cnt_clr;
  logic       dual_slope, cpu_wr, ovf_clr;
  logic [3:0] clk_sel;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       at_top, at_bottom, ovf_flag;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    m_cnt   = 0;
  bit    m_flg   = 1'b0;
  string cnt_tag = "R1";
  string flg_tag = "R9";
  bit    done    = 1'b0;

  always #5 clk = ~clk;

  bidir_tick_counter u0 (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .fast_tick(fast_tick),
    .clk_sel(clk_sel), .fast_en(fast_en), .cnt_en(cnt_en), .cnt_down(cnt_down),
    .cnt_clr(cnt_clr), .dual_slope(dual_slope), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .ovf_clr(ovf_clr), .cpu_rdata(cpu_rdata),
    .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(cnt_tag, 32'(cpu_rdata), 32'(m_cnt));
    chk("R6", 32'(at_top), 32'(m_cnt == 255));
    chk("R6", 32'(at_bottom), 32'(m_cnt == 0));
    chk(flg_tag, 32'(ovf_flag), 32'(m_flg));
  endtask

  // Called at a falling edge: applies inputs, advances the model, checks at next falling edge.
  task automatic drive(input bit wr, input logic [7:0] wd, input bit clr, input bit en,
                       input bit down, input bit dual, input bit oclr,
                       input logic [3:0] sel, input bit fe, input bit st, input bit ft);
    bit tick;
    bit evt;
    cpu_wr = wr; cpu_wdata = wd; cnt_clr = clr; cnt_en = en; cnt_down = down;
    dual_slope = dual; ovf_clr = oclr; clk_sel = sel; fast_en = fe;
    sys_tick = st; fast_tick = ft;
    tick = (sel != 0) && (fe ? ft : st);
    evt  = 1'b0;
    if (wr) m_cnt = int'(wd);
    else if (tick) begin
      if (clr) m_cnt = 0;
      else if (en && down) begin
        if (dual && m_cnt == 1) evt = 1'b1;
        m_cnt = (m_cnt + 255) % 256;
      end else if (en) begin
        if (!dual && m_cnt == 255) evt = 1'b1;
        m_cnt = (m_cnt + 1) % 256;
      end
    end
    if (evt) m_flg = 1'b1;
    else if (oclr) m_flg = 1'b0;
    if (wr) cnt_tag = (sel == 0) ? "R4" : "R5";
    else if (sel == 0) cnt_tag = "R3";
    else if (fe) cnt_tag = "R2";
    else cnt_tag = "R1";
    flg_tag = evt ? (dual ? "R8" : "R7") : "R9";
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_wr = 0; cpu_wdata = 0; cnt_clr = 0; cnt_en = 0; cnt_down = 0;
    dual_slope = 0; ovf_clr = 0; clk_sel = 0; fast_en = 0; sys_tick = 0; fast_tick = 0;
    repeat (3) @(negedge clk);
    chk("R10", 32'(cpu_rdata), 32'h0);
    chk("R10", 32'(ovf_flag), 32'h0);
    chk("R10", 32'(at_bottom), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: normal-mode up wrap
    drive(1, 8'hFE, 0, 0, 0, 0, 0, 4'h1, 0, 0, 0);
    drive(0, 8'h00, 0, 1, 0, 0, 0, 4'h1, 0, 1, 0);
    drive(0, 8'h00, 0, 1, 0, 0, 0, 4'h1, 0, 1, 0);
    // R9: clear strobe without tick
    drive(0, 8'h00, 0, 0, 0, 0, 1, 4'h1, 0, 0, 0);
    // R8: dual slope landing on zero, then down-wrap without set
    drive(1, 8'h02, 0, 0, 0, 1, 0, 4'h3, 0, 0, 0);
    drive(0, 8'h00, 0, 1, 1, 1, 0, 4'h3, 0, 1, 0);
    drive(0, 8'h00, 0, 1, 1, 1, 0, 4'h3, 0, 1, 0);
    drive(0, 8'h00, 0, 0, 0, 1, 1, 4'h3, 0, 0, 0);
    drive(0, 8'h00, 0, 1, 1, 1, 0, 4'h3, 0, 1, 0);
    // R8: up wrap in dual mode does not set
    drive(0, 8'h00, 0, 1, 0, 1, 0, 4'h3, 0, 1, 0);
    // R9: set beats simultaneous clear
    drive(1, 8'h01, 0, 0, 0, 1, 0, 4'h2, 0, 0, 0);
    drive(0, 8'h00, 0, 1, 1, 1, 1, 4'h2, 0, 1, 0);
    // R3: clock select zero holds despite strobes and clear
    drive(0, 8'h00, 1, 1, 0, 0, 1, 4'h0, 0, 1, 1);
    drive(0, 8'h00, 0, 1, 0, 0, 0, 4'h0, 1, 1, 1);
    // R4: write with no clock
    drive(1, 8'h5A, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0);
    // R2: fast source ignores sys strobe, then steps on fast strobe
    drive(0, 8'h00, 0, 1, 0, 0, 0, 4'h4, 1, 1, 0);
    drive(0, 8'h00, 0, 1, 0, 0, 0, 4'h4, 1, 0, 1);
    drive(0, 8'h00, 0, 1, 1, 0, 0, 4'h4, 0, 0, 1);
    // R5: write overrides clear and step on tick; no flag from write at FF
    drive(1, 8'hFF, 1, 1, 0, 0, 0, 4'h1, 0, 1, 0);
    drive(1, 8'h33, 0, 1, 0, 0, 0, 4'h1, 0, 1, 0);
    // R1: clear on tick
    drive(0, 8'h00, 1, 1, 0, 0, 0, 4'h1, 0, 1, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] wd;
      int pick;
      pick = int'($urandom_range(0, 4));
      wd = ($urandom_range(0, 1) == 1) ? 8'($urandom) : 8'(pick == 0 ? 8'hFE : pick == 1 ? 8'hFF :
           pick == 2 ? 8'h00 : pick == 3 ? 8'h01 : 8'h02);
      drive($urandom_range(0, 15) == 0, wd, $urandom_range(0, 31) == 0,
            $urandom_range(0, 3) != 0, ((i / 40) % 2) == 1, ((i / 300) % 2) == 1,
            $urandom_range(0, 15) == 0,
            ($urandom_range(0, 7) == 0) ? 4'h0 : 4'($urandom_range(1, 15)),
            ((i / 500) % 2) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule